// File: doc/BRIEF.md
# Zero-Overhead Loop FIR Sequencer

This block runs a single FIR output computation as a fixed, cycle-exact schedule. A start request latches the tap count N. The first step clears a wide accumulator and fetches the first sample and coefficient pair in the same cycle. Two bookkeeping cycles follow: one loads the hardware loop counter and one arms the loop. The loop body then runs back to back for N−1 cycles. In each of those cycles it multiplies the held pair, adds the product to the accumulator, fetches the next pair and advances both circular pointers. No cycle is spent on a loop branch. A last multiply-accumulate adds the rounding constant, and a saturation step clamps the accumulator only when it has left the 32-bit signed range. A return cycle raises `done`.

Sample and coefficient storage sit outside the block and are read asynchronously. The sample pointer and the coefficient pointer each walk their buffer upward and wrap at N−1. Store coefficients in reverse order so that the oldest sample meets the last tap. A full run advances each pointer exactly N times, so both come back to where they began. The sample pointer therefore rests on the oldest sample, ready for the next call.

Top module: `firLoopSeq`

## Requirements
- R1: After reset `busy` and `done` are low and both `dataAddr` and `coefAddr` are 0.
- R2: A `start` seen at a clock edge while idle makes `busy` high from the next cycle for exactly N+5 cycles. `done` is high in the last of those cycles, which is cycle N+5 counted from the accepting edge.
- R3: `done` lasts one cycle, and `busy` is low in the cycle after it.
- R4: A `start` raised while `busy` is high has no effect: the run keeps its length, and no second run follows.
- R5: The effective tap count is `tapCount` clamped to the range 2 to MAX_TAPS. Values 0 and 1 behave as 2, and values above MAX_TAPS behave as MAX_TAPS.
- R6: The run reads pair k (k = 0..N−1) from `dataAddr = (p0+k) mod N` and `coefAddr = (q0+k) mod N` as signed 16-bit words. p0 and q0 are the pointer values at start. The accumulator gathers the exact sum of the N signed products.
- R7: Rounding adds 2^15 to the final sum. While `done` is high, `result` is bits 31:16 of the rounded sum.
- R8: If the rounded sum exceeds 2^31−1, `result` is 0x7FFF. If it is below −2^31, `result` is 0x8000.
- R9: After a run both pointers hold their values from the start of the run, and they do not change while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one computation |
| tapCount | input | CW (5) | Requested tap count N |
| dataIn | input | DW (16) | Sample word read at `dataAddr` |
| coefIn | input | DW (16) | Coefficient word read at `coefAddr` |
| dataAddr | output | AW (4) | Sample buffer pointer |
| coefAddr | output | AW (4) | Coefficient buffer pointer |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | DW (16) | Rounded, saturated filter output |

## Verification
The bench drives `start` on a falling edge and takes the next rising edge as cycle 0. It then samples every falling edge with a running index, so `busy` must already be high at index 1 and `done` must appear at index N+5 and at no other index. `result` is compared in that same `done` cycle against a reference computed as a 64-bit sum of products, then rounded and clamped. `busy`, `done` and both pointers are checked one falling edge later and again after a few idle cycles. An extra `start` pulse placed inside a run must leave the index of `done` at N+5.

// File: rtl/firSeqPkg.sv
package firSeqPkg;
  typedef struct packed {
    logic latchN;
    logic clrAcc;
    logic fetch;
    logic loadCnt;
    logic decCnt;
    logic mac;
    logic rnd;
    logic sat;
  } seqStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_LDCNT, ST_ARM, ST_BODY, ST_LAST, ST_SATUR, ST_RET
  } seqState_t;
endpackage

// File: rtl/firSeqCtrl.sv
module firSeqCtrl
  import firSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       cntExpire,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.latchN = 1'b1;
          nextState     = ST_SETUP;
        end
      end
      ST_SETUP: begin
        strobe.clrAcc = 1'b1;
        strobe.fetch  = 1'b1;
        nextState     = ST_LDCNT;
      end
      ST_LDCNT: begin
        strobe.loadCnt = 1'b1;
        nextState      = ST_ARM;
      end
      ST_ARM:  nextState = ST_BODY;
      ST_BODY: begin
        strobe.mac    = 1'b1;
        strobe.fetch  = 1'b1;
        strobe.decCnt = 1'b1;
        if (cntExpire) nextState = ST_LAST;
      end
      ST_LAST: begin
        strobe.mac = 1'b1;
        strobe.rnd = 1'b1;
        nextState  = ST_SATUR;
      end
      ST_SATUR: begin
        strobe.sat = 1'b1;
        nextState  = ST_RET;
      end
      ST_RET:  nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_RET);
endmodule

// File: rtl/firSeqDatapath.sv
module firSeqDatapath
  import firSeqPkg::*;
#(
  parameter int DW       = 16,
  parameter int MAX_TAPS = 16,
  parameter int GB       = 8,
  localparam int AW      = $clog2(MAX_TAPS),
  localparam int CW      = $clog2(MAX_TAPS + 1),
  localparam int ACCW    = 2 * DW + GB
)(
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobe_t    strobe,
  input  logic [CW-1:0] tapCount,
  input  logic [DW-1:0] dataIn,
  input  logic [DW-1:0] coefIn,
  output logic [AW-1:0] dataAddr,
  output logic [AW-1:0] coefAddr,
  output logic          cntExpire,
  output logic [DW-1:0] result
);
  logic [CW-1:0]          nReg, nClamp, lastIdx, cnt;
  logic [AW-1:0]          dPtr, cPtr, dNext, cNext;
  logic signed [DW-1:0]   dReg, cReg;
  logic signed [2*DW-1:0] prod;
  logic [ACCW-1:0]        acc, prodExt, rndAdd;
  logic                   ovf;

  localparam logic [ACCW-1:0] SAT_MAX = {{(GB + 1){1'b0}}, {(2 * DW - 1){1'b1}}};
  localparam logic [ACCW-1:0] SAT_MIN = {{(GB + 1){1'b1}}, {(2 * DW - 1){1'b0}}};
  localparam logic [ACCW-1:0] RND_ONE = ACCW'(1) << (DW - 1);

  always_comb begin
    if (tapCount < CW'(2))             nClamp = CW'(2);
    else if (tapCount > CW'(MAX_TAPS)) nClamp = CW'(MAX_TAPS);
    else                               nClamp = tapCount;
  end

  assign lastIdx = nReg - CW'(1);
  assign dNext   = ({1'b0, dPtr} >= (CW + 1)'(lastIdx)) ? '0 : dPtr + AW'(1);
  assign cNext   = ({1'b0, cPtr} >= (CW + 1)'(lastIdx)) ? '0 : cPtr + AW'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nReg <= CW'(2);
      cnt  <= '0;
      dPtr <= '0;
      cPtr <= '0;
      dReg <= '0;
      cReg <= '0;
    end else begin
      if (strobe.latchN)  nReg <= nClamp;
      if (strobe.loadCnt) cnt  <= lastIdx;
      else if (strobe.decCnt) cnt <= cnt - CW'(1);
      if (strobe.fetch) begin
        dReg <= $signed(dataIn);
        cReg <= $signed(coefIn);
        dPtr <= dNext;
        cPtr <= cNext;
      end
    end
  end

  assign prod    = dReg * cReg;
  assign prodExt = {{GB{prod[2*DW-1]}}, prod};
  assign rndAdd  = strobe.rnd ? RND_ONE : '0;
  assign ovf     = (|acc[ACCW-1:2*DW-1]) && !(&acc[ACCW-1:2*DW-1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   acc <= '0;
    else if (strobe.clrAcc)      acc <= '0;
    else if (strobe.mac)         acc <= acc + prodExt + rndAdd;
    else if (strobe.sat && ovf)  acc <= acc[ACCW-1] ? SAT_MIN : SAT_MAX;
  end

  assign cntExpire = (cnt == CW'(1));
  assign dataAddr  = dPtr;
  assign coefAddr  = cPtr;
  assign result    = acc[2*DW-1:DW];
endmodule

// File: rtl/firLoopSeq.sv
module firLoopSeq
  import firSeqPkg::*;
#(
  parameter int DW       = 16,
  parameter int MAX_TAPS = 16,
  parameter int GB       = 8,
  localparam int AW      = $clog2(MAX_TAPS),
  localparam int CW      = $clog2(MAX_TAPS + 1)
)(
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [CW-1:0] tapCount,
  input  logic [DW-1:0] dataIn,
  input  logic [DW-1:0] coefIn,
  output logic [AW-1:0] dataAddr,
  output logic [AW-1:0] coefAddr,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] result
);
  seqStrobe_t strobe;
  logic       cntExpire;

  firSeqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .cntExpire(cntExpire),
    .strobe(strobe), .busy(busy), .done(done)
  );

  firSeqDatapath #(.DW(DW), .MAX_TAPS(MAX_TAPS), .GB(GB)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tapCount(tapCount),
    .dataIn(dataIn), .coefIn(coefIn), .dataAddr(dataAddr),
    .coefAddr(coefAddr), .cntExpire(cntExpire), .result(result)
  );
endmodule

// File: rtl/firLoopSeqChecker.sv
module firLoopSeqChecker #(
  parameter int AW = 4
)(
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] dataAddr,
  input logic [AW-1:0] coefAddr
);
  a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r3_idle_after_done: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  a_r2_done_within_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
  a_r2_start_accepted: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);
  a_r4_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);
  a_r9_ptr_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(dataAddr) && $stable(coefAddr)));
endmodule

bind firLoopSeq firLoopSeqChecker #(.AW(AW)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .dataAddr(dataAddr), .coefAddr(coefAddr)
);

// File: tb/sim_firLoopSeq.sv
module sim_firLoopSeq;
  localparam int DW = 16, MAXT = 16, AW = 4, CW = 5;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [CW-1:0] tapCount = '0;
  logic [DW-1:0] dataIn, coefIn, result;
  logic [AW-1:0] dataAddr, coefAddr;
  logic busy, done;
  logic signed [DW-1:0] dmem [MAXT];
  logic signed [DW-1:0] cmem [MAXT];
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign dataIn = dmem[dataAddr];
  assign coefIn = cmem[coefAddr];

  firLoopSeq u0 (.clk(clk), .rstN(rstN), .start(start), .tapCount(tapCount),
    .dataIn(dataIn), .coefIn(coefIn), .dataAddr(dataAddr), .coefAddr(coefAddr),
    .busy(busy), .done(done), .result(result));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill(input int mode, input int seed);
    for (int i = 0; i < MAXT; i++) begin
      case (mode)
        0: begin
          dmem[i] = DW'(((i * 37 + seed * 11) % 256 - 128) * (seed % 7 + 1));
          cmem[i] = DW'(((i * 53 + seed * 29) % 200 - 100) * (seed % 5 + 3));
        end
        1: begin dmem[i] = 16'sh7FFF; cmem[i] = 16'sh7FFF; end
        2: begin dmem[i] = 16'sh8000; cmem[i] = 16'sh7FFF; end
        default: begin dmem[i] = '0; cmem[i] = '0; end
      endcase
    end
  endtask

  function automatic int effN(input int req);
    if (req < 2) return 2;
    if (req > MAXT) return MAXT;
    return req;
  endfunction

  function automatic logic [DW-1:0] refOut(input int n);
    longint s = 0;
    for (int i = 0; i < n; i++) s += longint'(dmem[i]) * longint'(cmem[i]);
    s += 32768;
    if (s > 64'sd2147483647) return 16'h7FFF;
    if (s < -64'sd2147483648) return 16'h8000;
    return s[31:16];
  endfunction

  task automatic runOne(input int req, input bit inject);
    int n = effN(req);
    int k;
    logic [DW-1:0] exp = refOut(n);
    @(negedge clk);
    tapCount = CW'(req);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    k = 1;
    chk(busy === 1'b1, "R2 busy after accept", longint'(busy), 1);
    while (done !== 1'b1 && k < 200) begin
      start = (inject && k == 3);
      @(negedge clk);
      k++;
      if (done !== 1'b1) nChecks += 0;
    end
    start = 1'b0;
    if (inject) chk(k == n + 5, "R4 length with start while busy", k, n + 5);
    else if (req != n) chk(k == n + 5, "R5 clamped run length", k, n + 5);
    else chk(k == n + 5, "R2 run length", k, n + 5);
    chk(result === exp, "R6 R7 R8 result", longint'(result), longint'(exp));
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R3 pulse ends and idle",
        longint'({busy, done}), 0);
    chk(dataAddr === '0 && coefAddr === '0, "R9 pointers restored",
        longint'({dataAddr, coefAddr}), 0);
    if (inject) begin
      repeat (3) @(negedge clk);
      chk(busy === 1'b0, "R4 no second run", longint'(busy), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1 reset outputs", longint'({busy, done}), 0);
    chk(dataAddr === '0 && coefAddr === '0, "R1 reset pointers",
        longint'({dataAddr, coefAddr}), 0);
    rstN = 1'b1;
    fill(0, 1);
    for (int n = 2; n <= MAXT; n++) begin
      fill(0, n);
      runOne(n, 1'b0);
    end
    fill(0, 3);  runOne(0, 1'b0);   // R5 low clamp
    fill(0, 4);  runOne(1, 1'b0);   // R5 low clamp
    fill(0, 5);  runOne(20, 1'b0);  // R5 high clamp
    fill(0, 6);  runOne(9, 1'b1);   // R4
    fill(1, 0);  runOne(16, 1'b0);  // R8 positive
    fill(2, 0);  runOne(16, 1'b0);  // R8 negative
    fill(1, 0);  runOne(2, 1'b0);   // R8 in range, no clamp
    // R7 rounding boundaries
    fill(3, 0); dmem[0] = 16'sh0100; cmem[0] = 16'sh0080; runOne(2, 1'b0);
    fill(3, 0); dmem[0] = 16'sh0100; cmem[0] = 16'sh007F; runOne(2, 1'b0);
    fill(3, 0); dmem[1] = -16'sh0100; cmem[1] = 16'sh0080; runOne(2, 1'b0);
    fill(3, 0); dmem[1] = -16'sh0101; cmem[1] = 16'sh0080; runOne(3, 1'b0);
    repeat (4) @(negedge clk);
    chk(dataAddr === '0 && busy === 1'b0, "R9 idle stable",
        longint'(dataAddr), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule